// File: doc/BRIEF.md
# Critical-Word-First Line Fill Controller

This block runs the refill of one cache line after a miss. When a miss is accepted it issues one memory read per word of the line. In wrap mode the first read is for the word the processor missed on, and the rest follow in ascending order, wrapping back to word 0 after the last word. In sequential mode the reads run from word 0 upward. In both modes the processor gets a one-cycle restart strobe, carrying the missed word, in the cycle after that word comes back from memory. The remaining words keep arriving and are written into the data array behind it.

Every returned word is also kept in a local line buffer, together with a per-word filled flag. While the fill is running, a processor read to the line being filled is answered from that buffer if its word is already present. It is stalled if its word is not yet present. A second miss offered during a fill is held off until the line has been marked valid. Each word is 64 bits, the critical unit. Memory is assumed to answer in request order, at most one word per cycle.

Top module: `cwf_fill_ctrl`

## Requirements
- R1: In wrap mode (`miss_wrap`=1), the first memory read after a miss is accepted carries the missed word offset. It is presented in the cycle after acceptance, together with the missed line address.
- R2: In wrap mode, the word offset of read k (counting from 0) is (missed offset + k) modulo WORDS. Exactly WORDS reads are issued per fill.
- R3: In sequential mode (`miss_wrap`=0), the word offset of read k is k, for k = 0 to WORDS-1, whatever the missed offset is.
- R4: `cpu_restart` pulses for exactly one cycle per fill, in the cycle after the memory response that carries the missed word is accepted, with that word on `cpu_restart_data`. In wrap mode this is the cycle after the first response. In sequential mode it is the cycle after response number (missed offset).
- R5: Each accepted memory response appears on the array write port in the next cycle. `arr_wr_en` is 1, `arr_wr_word` is the offset of the matching read, `arr_wr_line` is the fill line, and `arr_wr_data` is the returned data.
- R6: `arr_line_valid` pulses once per fill, in the cycle after the last word write, and never at any other time.
- R7: `miss_ready` is 0 from the cycle after a miss is accepted through the cycle before the `arr_line_valid` pulse, and 1 otherwise. A miss held during a fill is accepted afterwards.
- R8: A processor read (`cpu_rd_valid`) to the filling line whose word has already been written gives `cpu_fwd_valid`=1 in the next cycle, with that word's data on `cpu_fwd_data`. It raises no stall.
- R9: A processor read to the filling line whose word has not yet been written raises `cpu_rd_stall` in the same cycle. It is not forwarded in the next cycle.
- R10: After reset, `miss_ready` is 1 and `mem_req_valid`, `cpu_restart`, `arr_wr_en`, `arr_line_valid` and `cpu_fwd_valid` are 0.
- R11: A processor read to any other line, or any read while no fill is running (including the valid-pulse cycle), raises neither a stall nor a forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request offered |
| miss_ready | output | 1 | Controller idle, miss accepted when both high |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | OFF_W | Word offset the processor missed on |
| miss_wrap | input | 1 | 1: wrap order from missed word, 0: sequential from word 0 |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_line | output | LINE_W | Line address of the request |
| mem_req_word | output | OFF_W | Word offset of the request |
| mem_rsp_valid | input | 1 | Memory returns one word, in request order |
| mem_rsp_data | input | WORD_W | Returned word |
| cpu_restart | output | 1 | One-cycle restart strobe for the processor |
| cpu_restart_data | output | WORD_W | The missed word, valid with the strobe |
| cpu_rd_valid | input | 1 | Processor read during a fill |
| cpu_rd_line | input | LINE_W | Line address of that read |
| cpu_rd_word | input | OFF_W | Word offset of that read |
| cpu_rd_stall | output | 1 | Read targets a word not yet filled |
| cpu_fwd_valid | output | 1 | Forwarded read data valid (one cycle after the read) |
| cpu_fwd_data | output | WORD_W | Forwarded read data |
| arr_wr_en | output | 1 | Data array word write enable |
| arr_wr_line | output | LINE_W | Line being written |
| arr_wr_word | output | OFF_W | Word offset being written |
| arr_wr_data | output | WORD_W | Word data being written |
| arr_line_valid | output | 1 | Set the valid bit of `arr_wr_line` |

## Verification
The assertions take three things for granted. The memory returns a word only for a read it has already accepted, in the order the reads were accepted. The miss inputs stay steady while `miss_valid` waits for `miss_ready`. A processor read is a one-cycle probe that may be dropped after a stall. The bench's memory model keeps a queue of accepted read offsets and answers only from its head, after a random delay, so responses never run ahead of requests and never reorder. Misses are offered and held until accepted, and sometimes re-offered at once, so the hold during a fill is exercised. Processor reads are fired at random cycles, mostly at the line being filled.

// File: rtl/cwf_pkg.sv
// Package cwf_pkg
// Shared types for the line fill controller.
package cwf_pkg;

    // Fill sequencer states: idle, words outstanding, last word being written
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_FILL = 2'd1,
        FS_LAST = 2'd2
    } fill_state_t;

endpackage

// File: rtl/cwf_word_order.sv
// Module cwf_word_order
// Maps a step count (0..WORDS-1) of a fill to a word offset. In wrap mode
// the order starts at the critical word and wraps modulo WORDS; otherwise
// the step count is the offset. Assumes crit and step are below WORDS.
module cwf_word_order #(
    parameter int WORDS = 4,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             wrap,
    input  logic [OFF_W-1:0] crit,
    input  logic [OFF_W-1:0] step,
    output logic [OFF_W-1:0] word
);

    generate
        if ((WORDS & (WORDS - 1)) == 0) begin : g_pow2
            // Power-of-two line: modulo falls out of the adder width
            always_comb word = wrap ? (crit + step) : step;
        end else begin : g_odd
            logic [OFF_W:0] sum;
            logic [OFF_W:0] folded;
            // Other line sizes: add then fold back once
            always_comb begin
                sum    = {1'b0, crit} + {1'b0, step};
                folded = (sum >= (OFF_W+1)'(WORDS)) ? sum - (OFF_W+1)'(WORDS) : sum;
                word   = wrap ? folded[OFF_W-1:0] : step;
            end
        end
    endgenerate

endmodule

// File: rtl/cwf_fill_seq.sv
// Module cwf_fill_seq
// Fill sequencer: accepts a miss when idle, counts issued memory reads and
// accepted responses, and pulses done one cycle after the last word write.
// Assumes memory answers only accepted reads, in order.
module cwf_fill_seq
    import cwf_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int LINE_W = 26,
    localparam int OFF_W = $clog2(WORDS),
    localparam int CNT_W = $clog2(WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_word,
    input  logic              miss_wrap,
    output logic              miss_ready,
    input  logic              mem_req_ready,
    output logic              mem_req_valid,
    input  logic              mem_rsp_valid,
    output logic              rsp_take,
    output logic [OFF_W-1:0]  req_step,
    output logic [OFF_W-1:0]  rsp_step,
    output logic [LINE_W-1:0] cur_line,
    output logic [OFF_W-1:0]  cur_crit,
    output logic              cur_wrap,
    output logic              busy,
    output logic              fill_start,
    output logic              done
);

    fill_state_t      state;
    logic [CNT_W-1:0] req_cnt;
    logic [CNT_W-1:0] rsp_cnt;

    // Handshake decode from the current state
    always_comb begin
        miss_ready    = (state == FS_IDLE);
        busy          = (state != FS_IDLE);
        fill_start    = miss_valid && miss_ready;
        mem_req_valid = (state == FS_FILL) && (req_cnt < CNT_W'(WORDS));
        rsp_take      = (state == FS_FILL) && mem_rsp_valid;
        req_step      = req_cnt[OFF_W-1:0];
        rsp_step      = rsp_cnt[OFF_W-1:0];
    end

    // State, counters and the latched miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FS_IDLE;
            req_cnt  <= '0;
            rsp_cnt  <= '0;
            cur_line <= '0;
            cur_crit <= '0;
            cur_wrap <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                FS_IDLE: begin
                    if (fill_start) begin
                        cur_line <= miss_line;
                        cur_crit <= miss_word;
                        cur_wrap <= miss_wrap;
                        req_cnt  <= '0;
                        rsp_cnt  <= '0;
                        state    <= FS_FILL;
                    end
                end
                FS_FILL: begin
                    if (mem_req_valid && mem_req_ready) begin
                        req_cnt <= req_cnt + 1'b1;
                    end
                    if (rsp_take) begin
                        rsp_cnt <= rsp_cnt + 1'b1;
                        if (rsp_cnt == CNT_W'(WORDS - 1)) begin
                            state <= FS_LAST;
                        end
                    end
                end
                FS_LAST: begin
                    done  <= 1'b1;
                    state <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cwf_fill_buf.sv
// Module cwf_fill_buf
// Registers each returned word onto the array write port, keeps a copy with
// a filled flag per word, and answers processor reads to the filling line:
// forward next cycle if filled, stall now if not. Flags clear on a new fill.
module cwf_fill_buf #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 64,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_take,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic              rd_line_hit,
    input  logic [OFF_W-1:0]  rd_word,
    output logic              arr_wr_en,
    output logic [OFF_W-1:0]  arr_wr_word,
    output logic [WORD_W-1:0] arr_wr_data,
    output logic              rd_stall,
    output logic              fwd_valid,
    output logic [WORD_W-1:0] fwd_data
);

    logic [WORDS-1:0]  filled;
    logic [WORD_W-1:0] store [WORDS];
    logic              rd_probe;

    // Read probe decode against the filled flags
    always_comb begin
        rd_probe = rd_valid && rd_line_hit;
        rd_stall = rd_probe && !filled[rd_word];
    end

    // Array write port registers and filled flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_wr_en   <= 1'b0;
            arr_wr_word <= '0;
            arr_wr_data <= '0;
            filled      <= '0;
        end else begin
            arr_wr_en <= wr_take;
            if (wr_take) begin
                arr_wr_word      <= wr_word;
                arr_wr_data      <= wr_data;
                filled[wr_word]  <= 1'b1;
            end
            if (clear) begin
                filled <= '0;
            end
        end
    end

    // Per-word copy of the line for forwarding
    generate
        for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
            always_ff @(posedge clk) begin
                if (wr_take && (wr_word == OFF_W'(gi))) begin
                    store[gi] <= wr_data;
                end
            end
        end
    endgenerate

    // Forward response one cycle after a read to a filled word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= rd_probe && filled[rd_word];
            if (rd_probe && filled[rd_word]) begin
                fwd_data <= store[rd_word];
            end
        end
    end

endmodule

// File: rtl/cwf_fill_ctrl.sv
// Module cwf_fill_ctrl
// Top of the line fill controller: sequencer, request and response order
// units, restart register and fill buffer. Assumes in-order memory returns
// and a power-of-two or general WORDS of at least 2.
module cwf_fill_ctrl #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 64,
    parameter int LINE_W = 26,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [LINE_W-1:0] miss_line,
    input  logic [OFF_W-1:0]  miss_word,
    input  logic              miss_wrap,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [LINE_W-1:0] mem_req_line,
    output logic [OFF_W-1:0]  mem_req_word,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              cpu_restart,
    output logic [WORD_W-1:0] cpu_restart_data,
    input  logic              cpu_rd_valid,
    input  logic [LINE_W-1:0] cpu_rd_line,
    input  logic [OFF_W-1:0]  cpu_rd_word,
    output logic              cpu_rd_stall,
    output logic              cpu_fwd_valid,
    output logic [WORD_W-1:0] cpu_fwd_data,
    output logic              arr_wr_en,
    output logic [LINE_W-1:0] arr_wr_line,
    output logic [OFF_W-1:0]  arr_wr_word,
    output logic [WORD_W-1:0] arr_wr_data,
    output logic              arr_line_valid
);

    logic              rsp_take;
    logic [OFF_W-1:0]  req_step;
    logic [OFF_W-1:0]  rsp_step;
    logic [OFF_W-1:0]  rsp_word;
    logic [LINE_W-1:0] cur_line;
    logic [OFF_W-1:0]  cur_crit;
    logic              cur_wrap;
    logic              busy;
    logic              fill_start;
    logic              done;
    logic              rd_line_hit;

    cwf_fill_seq #(.WORDS(WORDS), .LINE_W(LINE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_line     (miss_line),
        .miss_word     (miss_word),
        .miss_wrap     (miss_wrap),
        .miss_ready    (miss_ready),
        .mem_req_ready (mem_req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_take      (rsp_take),
        .req_step      (req_step),
        .rsp_step      (rsp_step),
        .cur_line      (cur_line),
        .cur_crit      (cur_crit),
        .cur_wrap      (cur_wrap),
        .busy          (busy),
        .fill_start    (fill_start),
        .done          (done)
    );

    cwf_word_order #(.WORDS(WORDS)) u_req_order (
        .wrap (cur_wrap),
        .crit (cur_crit),
        .step (req_step),
        .word (mem_req_word)
    );

    cwf_word_order #(.WORDS(WORDS)) u_rsp_order (
        .wrap (cur_wrap),
        .crit (cur_crit),
        .step (rsp_step),
        .word (rsp_word)
    );

    // Line address fan-out and read-probe line match
    always_comb begin
        mem_req_line   = cur_line;
        arr_wr_line    = cur_line;
        arr_line_valid = done;
        rd_line_hit    = busy && (cpu_rd_line == cur_line);
    end

    // Restart strobe when the missed word comes back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_restart      <= 1'b0;
            cpu_restart_data <= '0;
        end else begin
            cpu_restart <= rsp_take && (rsp_word == cur_crit);
            if (rsp_take && (rsp_word == cur_crit)) begin
                cpu_restart_data <= mem_rsp_data;
            end
        end
    end

    cwf_fill_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (fill_start),
        .wr_take     (rsp_take),
        .wr_word     (rsp_word),
        .wr_data     (mem_rsp_data),
        .rd_valid    (cpu_rd_valid),
        .rd_line_hit (rd_line_hit),
        .rd_word     (cpu_rd_word),
        .arr_wr_en   (arr_wr_en),
        .arr_wr_word (arr_wr_word),
        .arr_wr_data (arr_wr_data),
        .rd_stall    (cpu_rd_stall),
        .fwd_valid   (cpu_fwd_valid),
        .fwd_data    (cpu_fwd_data)
    );

endmodule

// File: rtl/cwf_fill_ctrl_chk.sv
// Module cwf_fill_ctrl_chk
// Port-level properties of the fill controller, bound to every instance.
// Assumes in-order memory returns for accepted reads only.
module cwf_fill_ctrl_chk #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 64,
    parameter int LINE_W = 26,
    localparam int OFF_W = $clog2(WORDS),
    localparam int CW    = $clog2(WORDS + 2)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miss_valid,
    input logic              miss_ready,
    input logic [OFF_W-1:0]  miss_word,
    input logic              miss_wrap,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [OFF_W-1:0]  mem_req_word,
    input logic              cpu_restart,
    input logic              cpu_rd_stall,
    input logic              cpu_fwd_valid,
    input logic              arr_wr_en,
    input logic              arr_line_valid
);

    logic [1:0]    rs_cnt;
    logic [CW-1:0] wr_cnt;
    logic          fire;

    always_comb fire = miss_valid && miss_ready;

    // Count restarts and word writes since the last accepted miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_cnt <= '0;
            wr_cnt <= '0;
        end else if (fire) begin
            rs_cnt <= '0;
            wr_cnt <= '0;
        end else begin
            if (cpu_restart && rs_cnt != 2'd3) rs_cnt <= rs_cnt + 1'b1;
            if (arr_wr_en && wr_cnt != '1) wr_cnt <= wr_cnt + 1'b1;
        end
    end

    // R1 / R3: first read is the missed word (wrap) or word 0 (sequential)
    p_first_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> mem_req_valid &&
                 mem_req_word == ($past(miss_wrap) ? $past(miss_word) : OFF_W'(0)));

    // R2: consecutive reads step by one, wrapping at the line end
    p_req_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=>
            (!mem_req_valid ||
             mem_req_word == (($past(mem_req_word) == OFF_W'(WORDS - 1)) ?
                              OFF_W'(0) : $past(mem_req_word) + 1'b1)));

    // R4: at most one restart per fill
    p_one_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_restart |-> rs_cnt == 2'd0);

    // R4 / R6: line valid only after every word and the restart
    p_valid_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_line_valid |-> (wr_cnt == CW'(WORDS)) && (rs_cnt == 2'd1) && !arr_wr_en);

    // R7: no miss accepted while words are being written
    p_hold_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> !miss_ready);

    // R9: a stalled read is never forwarded
    p_stall_no_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd_stall |=> !cpu_fwd_valid);

endmodule

bind cwf_fill_ctrl cwf_fill_ctrl_chk #(
    .WORDS  (WORDS),
    .WORD_W (WORD_W),
    .LINE_W (LINE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .miss_valid     (miss_valid),
    .miss_ready     (miss_ready),
    .miss_word      (miss_word),
    .miss_wrap      (miss_wrap),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_word   (mem_req_word),
    .cpu_restart    (cpu_restart),
    .cpu_rd_stall   (cpu_rd_stall),
    .cpu_fwd_valid  (cpu_fwd_valid),
    .arr_wr_en      (arr_wr_en),
    .arr_line_valid (arr_line_valid)
);

// File: tb/cwf_fill_ctrl_bench.sv
// Bench for cwf_fill_ctrl: memory model with random latency, a per-cycle
// reference model of order, restart, writes, valid and read probes.
module cwf_fill_ctrl_bench;

    localparam int WORDS  = 4;
    localparam int WORD_W = 64;
    localparam int LINE_W = 26;
    localparam int OFF_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic              miss_ready;
    logic [LINE_W-1:0] miss_line = '0;
    logic [OFF_W-1:0]  miss_word = '0;
    logic              miss_wrap = 1'b0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [LINE_W-1:0] mem_req_line;
    logic [OFF_W-1:0]  mem_req_word;
    logic              mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0] mem_rsp_data = '0;
    logic              cpu_restart;
    logic [WORD_W-1:0] cpu_restart_data;
    logic              cpu_rd_valid = 1'b0;
    logic [LINE_W-1:0] cpu_rd_line = '0;
    logic [OFF_W-1:0]  cpu_rd_word = '0;
    logic              cpu_rd_stall;
    logic              cpu_fwd_valid;
    logic [WORD_W-1:0] cpu_fwd_data;
    logic              arr_wr_en;
    logic [LINE_W-1:0] arr_wr_line;
    logic [OFF_W-1:0]  arr_wr_word;
    logic [WORD_W-1:0] arr_wr_data;
    logic              arr_line_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [LINE_W-1:0] last_line = '0;

    always #4 clk = ~clk;

    cwf_fill_ctrl #(.WORDS(WORDS), .WORD_W(WORD_W), .LINE_W(LINE_W)) u_cwf_fill_ctrl (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
        .miss_word(miss_word), .miss_wrap(miss_wrap),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_req_word(mem_req_word),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .cpu_restart(cpu_restart), .cpu_restart_data(cpu_restart_data),
        .cpu_rd_valid(cpu_rd_valid), .cpu_rd_line(cpu_rd_line), .cpu_rd_word(cpu_rd_word),
        .cpu_rd_stall(cpu_rd_stall), .cpu_fwd_valid(cpu_fwd_valid), .cpu_fwd_data(cpu_fwd_data),
        .arr_wr_en(arr_wr_en), .arr_wr_line(arr_wr_line), .arr_wr_word(arr_wr_word),
        .arr_wr_data(arr_wr_data), .arr_line_valid(arr_line_valid)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W-1:0] mem_word(input logic [LINE_W-1:0] l, input int w);
        return {6'h2A, l, 32'(w * 32'h1111_0001 + 32'h0BAD_0000)};
    endfunction

    function automatic int ord(input bit wrap, input int crit, input int i);
        return wrap ? (crit + i) % WORDS : i;
    endfunction

    // Memory model and per-cycle reference checks, evaluated at the falling edge
    initial begin : monitor
        bit busy = 0, fire_q = 0, rsp_q = 0, valid_due = 0, fwd_exp = 0, f_wrap = 0;
        int req_i = 0, rsp_i = 0, f_crit = 0;
        logic [LINE_W-1:0] f_line = '0;
        logic [WORDS-1:0] filled_m = '0;
        logic [WORD_W-1:0] fwd_d = '0;
        int q[$];
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                busy = 0; fire_q = 0; rsp_q = 0; valid_due = 0; fwd_exp = 0;
                q.delete(); mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
            end else begin
                // R6: valid pulse one cycle after the last write
                if (valid_due) begin
                    chk(arr_line_valid == 1'b1, "R6", "line valid pulse", 64'(arr_line_valid), 1);
                    busy = 0; valid_due = 0;
                end else begin
                    chk(arr_line_valid == 1'b0, "R6", "no stray valid", 64'(arr_line_valid), 0);
                end
                if (fire_q) begin
                    busy = 1; req_i = 0; rsp_i = 0; filled_m = '0; fire_q = 0;
                end
                // R5 / R4: effects of the response accepted at the last edge
                if (rsp_q) begin
                    automatic int w = ord(f_wrap, f_crit, rsp_i);
                    chk(arr_wr_en == 1'b1, "R5", "write enable", 64'(arr_wr_en), 1);
                    chk(arr_wr_word == OFF_W'(w), "R5", "write word", 64'(arr_wr_word), 64'(w));
                    chk(arr_wr_line == f_line, "R5", "write line", 64'(arr_wr_line), 64'(f_line));
                    chk(arr_wr_data == mem_word(f_line, w), "R5", "write data",
                        arr_wr_data, mem_word(f_line, w));
                    chk(cpu_restart == (w == f_crit), "R4", "restart cycle",
                        64'(cpu_restart), 64'(w == f_crit));
                    if (w == f_crit)
                        chk(cpu_restart_data == mem_word(f_line, w), "R4", "restart data",
                            cpu_restart_data, mem_word(f_line, w));
                    filled_m[w] = 1'b1;
                    rsp_i++;
                    if (rsp_i == WORDS) valid_due = 1;
                end else begin
                    chk(arr_wr_en == 1'b0, "R5", "no stray write", 64'(arr_wr_en), 0);
                    chk(cpu_restart == 1'b0, "R4", "no stray restart", 64'(cpu_restart), 0);
                end
                rsp_q = 0;
                // R8: forward from the previous cycle's read
                chk(cpu_fwd_valid == fwd_exp, "R8", "forward valid", 64'(cpu_fwd_valid), 64'(fwd_exp));
                if (fwd_exp)
                    chk(cpu_fwd_data == fwd_d, "R8", "forward data", cpu_fwd_data, fwd_d);
                // R9 / R11: stall decode for the current read
                begin
                    automatic bit match = cpu_rd_valid && busy && (cpu_rd_line == f_line);
                    automatic bit stall_e = match && !filled_m[cpu_rd_word];
                    chk(cpu_rd_stall == stall_e, match ? "R9" : "R11", "read stall",
                        64'(cpu_rd_stall), 64'(stall_e));
                    fwd_exp = match && filled_m[cpu_rd_word];
                    fwd_d = mem_word(f_line, int'(cpu_rd_word));
                end
                // R7: ready only while no fill runs
                chk(miss_ready == !busy, "R7", "miss ready", 64'(miss_ready), 64'(!busy));
                if (miss_valid && miss_ready) begin
                    fire_q = 1; f_line = miss_line; f_crit = int'(miss_word); f_wrap = miss_wrap;
                end
                // Memory: answer from the queue head, in request order
                if (q.size() > 0 && ($urandom % 3) != 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = mem_word(f_line, q.pop_front());
                    rsp_q = 1;
                end else begin
                    mem_rsp_valid = 1'b0;
                end
                mem_req_ready = (($urandom % 4) != 0);
                chk(mem_req_valid == (busy && req_i < WORDS), "R2", "request valid",
                    64'(mem_req_valid), 64'(busy && req_i < WORDS));
                if (mem_req_valid && mem_req_ready) begin
                    automatic int e = ord(f_wrap, f_crit, req_i);
                    chk(mem_req_word == OFF_W'(e),
                        f_wrap ? ((req_i == 0) ? "R1" : "R2") : "R3", "request order",
                        64'(mem_req_word), 64'(e));
                    chk(mem_req_line == f_line, "R1", "request line",
                        64'(mem_req_line), 64'(f_line));
                    q.push_back(int'(mem_req_word));
                    req_i++;
                end
            end
        end
    end

    // Offer one miss and hold it until accepted
    task automatic do_miss(input logic [LINE_W-1:0] l, input int w, input bit wrap);
        bit taken;
        @(posedge clk); #1;
        miss_valid = 1'b1; miss_line = l; miss_word = OFF_W'(w); miss_wrap = wrap;
        last_line = l;
        forever begin
            @(negedge clk);
            taken = miss_ready;
            @(posedge clk); #1;
            if (taken) break;
        end
        miss_valid = 1'b0;
    endtask

    // Random processor read probes, mostly at the current line
    initial begin : reads
        forever begin
            @(posedge clk); #1;
            cpu_rd_valid = ($urandom % 2) == 1;
            cpu_rd_line = (($urandom % 4) != 0) ? last_line : LINE_W'($urandom);
            cpu_rd_word = OFF_W'($urandom);
        end
    end

    // Main sequence
    initial begin : driver
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(miss_ready == 1'b1, "R10", "reset ready", 64'(miss_ready), 1);
        chk(mem_req_valid == 1'b0, "R10", "reset req", 64'(mem_req_valid), 0);
        chk(cpu_restart == 1'b0, "R10", "reset restart", 64'(cpu_restart), 0);
        chk(arr_wr_en == 1'b0, "R10", "reset write", 64'(arr_wr_en), 0);
        chk(arr_line_valid == 1'b0, "R10", "reset valid", 64'(arr_line_valid), 0);
        chk(cpu_fwd_valid == 1'b0, "R10", "reset forward", 64'(cpu_fwd_valid), 0);
        // Directed: every offset in both modes, back to back (R1 R3 R4 R7)
        for (int m = 1; m >= 0; m--)
            for (int off = 0; off < WORDS; off++)
                do_miss(LINE_W'($urandom), off, bit'(m));
        // Same line refilled twice in a row
        do_miss(26'h155_5555, WORDS - 1, 1'b1);
        do_miss(26'h155_5555, WORDS - 1, 1'b1);
        // Random misses with idle gaps
        for (int n = 0; n < 40; n++) begin
            do_miss(LINE_W'($urandom), int'($urandom % WORDS), bit'($urandom % 2));
            repeat ($urandom % 6) @(posedge clk);
        end
        repeat (60) @(posedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule